// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns a binary64 operand into a signed or unsigned 32-bit or 64-bit integer and returns it in a 64-bit register image. A single-precision option treats the operand as a binary32 value stored in binary64 layout. The result is registered one cycle after the request, together with a write enable, rounding status, sticky exception requests and an overflow indication. Status-register storage and illegal-instruction trapping belong to the surrounding pipeline. The block only reports an unsupported mode on `bad_mode`.

A three-bit mode selects how values that do not fit the target type are treated. Two modes saturate to the type limits and send NaN to the type minimum. Two modes saturate and send NaN to zero. Two modes wrap modulo the type width and send NaN and infinity to zero. The top mode bit also forces truncation in place of the rounding mode in effect.

Top module: `fp2int_conv`

## Requirements
- R1: When `cvt_mode[2]` is 1 the value is rounded toward zero. Otherwise `rmode` selects the rounding: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R2: `int_kind[0]`=1 selects an unsigned target and `int_kind[1]`=1 selects a 64-bit target. The ranges are [-2^31, 2^31-1], [0, 2^32-1], [-2^63, 2^63-1] and [0, 2^64-1]. A rounded value inside the range is returned exactly. A 32-bit result is sign-extended to 64 bits when signed and zero-extended when unsigned.
- R3: Modes 0 and 1 (`cvt_mode[2:1]`=00) return the type maximum for values above the range, including +infinity. Values below the range, including -infinity, and NaN return the type minimum.
- R4: Modes 2 and 3 (`cvt_mode[2:1]`=01) behave as R3 except that NaN returns zero.
- R5: Modes 4 and 5 (`cvt_mode[2:1]`=10) return zero for NaN, for infinity and for magnitudes of 2^128 or more. Any other value returns its rounded value modulo 2^32 or 2^64, in two's complement.
- R6: Modes 6 and 7 raise `bad_mode` and produce no write, no flags and no exception requests.
- R7: When `single_mode` is 1 the 29 least significant fraction bits of the operand are ignored, so the operand is narrowed to binary32 precision before conversion.
- R8: `req_snan_inv` is raised for a NaN whose most significant fraction bit is 0. `req_cvt_inv` is raised for any NaN, and in modes 0 to 3 also for infinity and for out-of-range values.
- R9: If `trap_en` is 1 and either invalid request is raised, then `wr_en`, `flag_rounded`, `flag_inexact` and `ovf` are 0, and the invalid requests are still reported.
- R10: When the result is the rounded value itself (R2 or the finite case of R5), `flag_inexact` and `req_inexact` are 1 if that value differs from the source. `flag_rounded` is 1 if its magnitude exceeds the source magnitude. For saturated, NaN and infinity results these flags are 0.
- R11: When the result is written, `ovf` is 1 if the source is NaN or if the 64-bit result, read as the target type, does not equal the source value.
- R12: Outputs respond one clock after `in_valid`. `done` marks that cycle, and when `done` is 0 every other output is 0. `result` is 0 whenever `wr_en` is 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion request |
| op_bits | input | 64 | Floating-point operand, binary64 layout |
| cvt_mode | input | 3 | Out-of-range policy and forced truncation |
| int_kind | input | 2 | Target integer type |
| single_mode | input | 1 | Narrow the operand to binary32 precision |
| rmode | input | 2 | Rounding mode |
| trap_en | input | 1 | Invalid-operation trap enable |
| done | output | 1 | Response cycle of a request |
| wr_en | output | 1 | Destination write enable |
| result | output | 64 | Integer result image |
| flag_rounded | output | 1 | Magnitude was increased by rounding |
| flag_inexact | output | 1 | Result differs from the source |
| req_snan_inv | output | 1 | Signaling-NaN invalid request |
| req_cvt_inv | output | 1 | Conversion-invalid request |
| req_inexact | output | 1 | Inexact sticky request |
| ovf | output | 1 | Result does not represent the source |
| bad_mode | output | 1 | Unsupported conversion mode |

## Verification
The bench sweeps every mode, target type, rounding mode, single flag and trap setting over a list of operands chosen at the edges. The list includes signed zeros, subnormals, ties at .5, values next to ±2^31, ±2^63 and 2^64, magnitudes around 2^128, infinities, and quiet and signaling NaNs. A design with an off-by-one range test would saturate -2^31 or wrongly accept 2^31. A design that misplaced the tie rule would round 0.5 or 2.5 up. A wraparound that skipped the 2^128 cut-off, or lost low bits for large magnitudes, would return nonzero junk. A design that narrowed the signaling-NaN payload the wrong way would classify a narrowed NaN as infinity, or the reverse, and report the wrong invalid requests. Expected values come from real-number arithmetic in the bench, with the modulo taken on the magnitude so that no step rounds.

// File: rtl/fp2int_conv.sv
module fp2int_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] op_bits,
  input  logic [2:0]  cvt_mode,
  input  logic [1:0]  int_kind,
  input  logic        single_mode,
  input  logic [1:0]  rmode,
  input  logic        trap_en,
  output logic        done,
  output logic        wr_en,
  output logic [63:0] result,
  output logic        flag_rounded,
  output logic        flag_inexact,
  output logic        req_snan_inv,
  output logic        req_cvt_inv,
  output logic        req_inexact,
  output logic        ovf,
  output logic        bad_mode
);
  localparam logic [10:0] EXP_SHL  = 11'd1075;
  localparam logic [10:0] EXP_FRAC = 11'd1021;
  localparam logic [10:0] EXP_HUGE = 11'd1151;

  logic [63:0] src;
  assign src = single_mode ? {op_bits[63:29], 29'd0} : op_bits;

  logic        sgn;
  logic [10:0] ex;
  logic [51:0] fr;
  assign sgn = src[63];
  assign ex  = src[62:52];
  assign fr  = src[51:0];

  logic is_nan, is_inf, is_snan, huge;
  assign is_nan  = (&ex) && (|fr);
  assign is_inf  = (&ex) && !(|fr);
  assign is_snan = is_nan && !fr[51];
  assign huge    = ex >= EXP_HUGE;

  logic [52:0] sig;
  assign sig = {|ex, fr};

  logic [127:0] mag_t;
  logic [63:0]  sig64;
  logic [6:0]   rsh;
  logic         grd, stk;

  always_comb begin
    mag_t = '0;
    grd   = 1'b0;
    stk   = 1'b0;
    sig64 = {11'd0, sig};
    rsh   = 7'd1;
    if (ex >= EXP_SHL) begin
      mag_t = {75'd0, sig} << (ex - EXP_SHL);
    end else if (ex >= EXP_FRAC) begin
      rsh   = 7'(EXP_SHL - ex);
      mag_t = {64'd0, sig64 >> rsh};
      grd   = sig64[rsh - 7'd1];
      stk   = |(sig64 & ((64'd1 << (rsh - 7'd1)) - 64'd1));
    end else begin
      stk = |sig;
    end
  end

  logic truncate, incr;
  assign truncate = cvt_mode[2] || (rmode == 2'b01);

  always_comb begin
    incr = 1'b0;
    if (!truncate) begin
      case (rmode)
        2'b00:   incr = grd && (stk || mag_t[0]);
        2'b10:   incr = !sgn && (grd || stk);
        2'b11:   incr = sgn && (grd || stk);
        default: incr = 1'b0;
      endcase
    end
  end

  logic [127:0] mag;
  assign mag = mag_t + {127'd0, incr};

  logic pos_ok, neg_ok;
  always_comb begin
    case (int_kind)
      2'b00: begin
        pos_ok = mag[127:31] == '0;
        neg_ok = pos_ok || (mag == 128'h8000_0000);
      end
      2'b01: begin
        pos_ok = mag[127:32] == '0;
        neg_ok = mag == '0;
      end
      2'b10: begin
        pos_ok = mag[127:63] == '0;
        neg_ok = pos_ok || (mag == (128'd1 << 63));
      end
      default: begin
        pos_ok = mag[127:64] == '0;
        neg_ok = mag == '0;
      end
    endcase
  end

  logic fits;
  assign fits = !huge && (sgn ? neg_ok : pos_ok);

  logic [63:0] max_v, min_v;
  always_comb begin
    case (int_kind)
      2'b00:   begin max_v = 64'h0000_0000_7FFF_FFFF; min_v = 64'hFFFF_FFFF_8000_0000; end
      2'b01:   begin max_v = 64'h0000_0000_FFFF_FFFF; min_v = 64'd0; end
      2'b10:   begin max_v = 64'h7FFF_FFFF_FFFF_FFFF; min_v = 64'h8000_0000_0000_0000; end
      default: begin max_v = 64'hFFFF_FFFF_FFFF_FFFF; min_v = 64'd0; end
    endcase
  end

  logic mode_arch, mode_wrap, mode_bad;
  assign mode_arch = cvt_mode[2:1] == 2'b00;
  assign mode_wrap = cvt_mode[2:1] == 2'b10;
  assign mode_bad  = cvt_mode[2:1] == 2'b11;

  logic [63:0] twos, raw, fin;
  assign twos = sgn ? (~mag[63:0] + 64'd1) : mag[63:0];

  always_comb begin
    if (is_nan)         raw = mode_arch ? min_v : 64'd0;
    else if (mode_wrap) raw = huge ? 64'd0 : twos;
    else if (!fits)     raw = sgn ? min_v : max_v;
    else                raw = twos;
  end

  assign fin = int_kind[1] ? raw :
               int_kind[0] ? {32'd0, raw[31:0]} : {{32{raw[31]}}, raw[31:0]};

  logic exact_path, xx, cvinv, vex, ovf_c, wr_c;
  assign exact_path = !is_nan && (fits || (mode_wrap && !huge));
  assign xx         = exact_path && (grd || stk);
  assign cvinv      = is_nan || (!mode_wrap && !fits);
  assign vex        = trap_en && (is_snan || cvinv);
  assign ovf_c      = is_nan || !fits || grd || stk;
  assign wr_c       = !mode_bad && !vex;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      wr_en        <= 1'b0;
      result       <= '0;
      flag_rounded <= 1'b0;
      flag_inexact <= 1'b0;
      req_snan_inv <= 1'b0;
      req_cvt_inv  <= 1'b0;
      req_inexact  <= 1'b0;
      ovf          <= 1'b0;
      bad_mode     <= 1'b0;
    end else begin
      done         <= in_valid;
      wr_en        <= in_valid && wr_c;
      result       <= (in_valid && wr_c) ? fin : 64'd0;
      flag_rounded <= in_valid && wr_c && exact_path && incr;
      flag_inexact <= in_valid && wr_c && xx;
      req_snan_inv <= in_valid && !mode_bad && is_snan;
      req_cvt_inv  <= in_valid && !mode_bad && cvinv;
      req_inexact  <= in_valid && !mode_bad && xx;
      ovf          <= in_valid && wr_c && ovf_c;
      bad_mode     <= in_valid && mode_bad;
    end
  end
endmodule

module fp2int_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        trap_en,
  input logic [63:0] op_bits,
  input logic [2:0]  cvt_mode,
  input logic        done,
  input logic        wr_en,
  input logic [63:0] result,
  input logic        flag_rounded,
  input logic        flag_inexact,
  input logic        req_snan_inv,
  input logic        req_cvt_inv,
  input logic        ovf,
  input logic        bad_mode
);
  logic op_nan;
  assign op_nan = (&op_bits[62:52]) && (|op_bits[51:29]);

  AST_DONE_TRACKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done); // R12
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!wr_en && !ovf && !bad_mode && !req_cvt_inv && result == 64'd0)); // R12
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> (!wr_en && !req_cvt_inv && !flag_inexact)); // R6
  AST_SNAN_IS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_snan_inv |-> req_cvt_inv); // R8
  AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trap_en) && (req_snan_inv || req_cvt_inv)) |-> (!wr_en && !flag_rounded && !flag_inexact && !ovf)); // R9
  AST_ROUND_NEEDS_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rounded |-> flag_inexact); // R10
  AST_OVF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> wr_en); // R11
  AST_INEXACT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inexact |-> ovf); // R11
  AST_SAT_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(cvt_mode[2:1] == 2'b01 && op_nan)) |-> (result == 64'd0)); // R4
endmodule

bind fp2int_conv fp2int_conv_chk i_chk (.*);

// File: tb/test_fp2int_conv.sv
module test_fp2int_conv;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, in_valid, single_mode, trap_en;
  logic [63:0] op_bits;
  logic [2:0]  cvt_mode;
  logic [1:0]  int_kind, rmode;
  logic        done, wr_en, flag_rounded, flag_inexact;
  logic        req_snan_inv, req_cvt_inv, req_inexact, ovf, bad_mode;
  logic [63:0] result;

  fp2int_conv i_fp2int_conv (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam real P31  = 2147483648.0;
  localparam real P32  = 4294967296.0;
  localparam real P63  = 9223372036854775808.0;
  localparam real P64  = 18446744073709551616.0;
  localparam real P128 = 340282366920938463463374607431768211456.0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] op, input logic [2:0] m, input logic [1:0] k,
                       input logic sm, input logic [1:0] rm, input logic te);
    op_bits = op; cvt_mode = m; int_kind = k; single_mode = sm; rmode = rm; trap_en = te;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic model(input logic [63:0] op, input logic [2:0] m, input logic [1:0] k,
                       input logic sm, input logic [1:0] rm, input logic te,
                       output logic [63:0] e_res, output logic e_wr, output logic e_rnd,
                       output logic e_inx, output logic e_sn, output logic e_cv,
                       output logic e_ovf, output logic e_bad);
    logic [63:0] s, bits, maxv, minv, modv;
    bit nan, inf, neg, fits, wrap, exact, vex;
    real v, r, f, d, a, ua, lo, hiex, mm;
    s   = sm ? {op[63:29], 29'd0} : op;
    nan = (s[62:52] == 11'h7FF) && (s[51:0] != 52'd0);
    inf = (s[62:52] == 11'h7FF) && (s[51:0] == 52'd0);
    neg = s[63];
    v = 0.0; r = 0.0;
    if (!nan && !inf) begin
      v = $bitstoreal(s);
      if (m[2] || rm == 2'b01) r = (v < 0.0) ? $ceil(v) : $floor(v);
      else if (rm == 2'b10) r = $ceil(v);
      else if (rm == 2'b11) r = $floor(v);
      else begin
        f = $floor(v); d = v - f;
        if (d > 0.5) r = f + 1.0;
        else if (d < 0.5) r = f;
        else r = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
    end
    case (k)
      2'b00:   begin lo = -P31; hiex = P31; maxv = 64'h0000_0000_7FFF_FFFF; minv = 64'hFFFF_FFFF_8000_0000; end
      2'b01:   begin lo = 0.0;  hiex = P32; maxv = 64'h0000_0000_FFFF_FFFF; minv = 64'd0; end
      2'b10:   begin lo = -P63; hiex = P63; maxv = 64'h7FFF_FFFF_FFFF_FFFF; minv = 64'h8000_0000_0000_0000; end
      default: begin lo = 0.0;  hiex = P64; maxv = 64'hFFFF_FFFF_FFFF_FFFF; minv = 64'd0; end
    endcase
    fits = !nan && !inf && (r >= lo) && (r < hiex);
    a  = (r < 0.0) ? -r : r;
    mm = k[1] ? P64 : P32;
    ua = a - mm * $floor(a / mm);
    bits = (ua >= P63) ? (64'(longint'(ua - P63)) | 64'h8000_0000_0000_0000) : 64'(longint'(ua));
    if (r < 0.0) bits = ~bits + 64'd1;
    modv = k[1] ? bits : (k[0] ? {32'd0, bits[31:0]} : {{32{bits[31]}}, bits[31:0]});
    wrap = (m[2:1] == 2'b10);
    e_bad = (m[2:1] == 2'b11);
    if (nan) e_res = (m[2:1] == 2'b00) ? minv : 64'd0;
    else if (wrap) e_res = (inf || a >= P128) ? 64'd0 : modv;
    else if (!fits) e_res = neg ? minv : maxv;
    else e_res = modv;
    exact = !nan && !inf && (fits || (wrap && a < P128));
    e_sn  = !e_bad && nan && !s[51];
    e_cv  = !e_bad && (nan || (!wrap && !fits));
    vex   = te && (e_sn || e_cv);
    e_wr  = !e_bad && !vex;
    e_inx = exact && (r != v);
    e_rnd = e_wr && exact && (a > ((v < 0.0) ? -v : v));
    e_ovf = e_wr && (nan || !fits || r != v);
    if (!e_wr) e_res = 64'd0;
  endtask

  task automatic run_one(input logic [63:0] op, input logic [2:0] m, input logic [1:0] k,
                         input logic sm, input logic [1:0] rm, input logic te);
    logic [63:0] e_res;
    logic e_wr, e_rnd, e_inx, e_sn, e_cv, e_ovf, e_bad;
    string rt;
    model(op, m, k, sm, rm, te, e_res, e_wr, e_rnd, e_inx, e_sn, e_cv, e_ovf, e_bad);
    drive(op, m, k, sm, rm, te);
    case (m[2:1])
      2'b00:   rt = "R3";
      2'b01:   rt = "R4";
      2'b10:   rt = "R5";
      default: rt = "R6";
    endcase
    chk("R12", "done", {63'd0, done}, 64'd1);
    chk(rt, "result", result, e_res);
    chk("R9", "wr_en", {63'd0, wr_en}, {63'd0, e_wr});
    chk("R10", "rounded", {63'd0, flag_rounded}, {63'd0, e_rnd});
    chk("R10", "inexact", {62'd0, flag_inexact, req_inexact}, {62'd0, e_inx && e_wr, e_inx && !e_bad});
    chk("R8", "invalid_reqs", {62'd0, req_snan_inv, req_cvt_inv}, {62'd0, e_sn, e_cv});
    chk("R11", "ovf", {63'd0, ovf}, {63'd0, e_ovf});
    chk("R6", "bad_mode", {63'd0, bad_mode}, {63'd0, e_bad});
  endtask

  logic [63:0] vals [40];

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_bits = '0; cvt_mode = '0; int_kind = '0;
    single_mode = 1'b0; rmode = '0; trap_en = 1'b0;
    vals[0]  = 64'h0000_0000_0000_0000;
    vals[1]  = 64'h8000_0000_0000_0000;
    vals[2]  = 64'h0000_0000_0000_0001;
    vals[3]  = 64'h800F_FFFF_FFFF_FFFF;
    vals[4]  = $realtobits(0.5);
    vals[5]  = $realtobits(-0.5);
    vals[6]  = $realtobits(1.5);
    vals[7]  = $realtobits(2.5);
    vals[8]  = $realtobits(-2.5);
    vals[9]  = $realtobits(0.3);
    vals[10] = $realtobits(-0.7);
    vals[11] = $realtobits(3.0);
    vals[12] = $realtobits(-3.7);
    vals[13] = $realtobits(2147483647.5);
    vals[14] = $realtobits(2147483648.0);
    vals[15] = $realtobits(-2147483648.0);
    vals[16] = $realtobits(-2147483648.5);
    vals[17] = $realtobits(-2147483649.0);
    vals[18] = $realtobits(4294967295.0);
    vals[19] = $realtobits(4294967295.5);
    vals[20] = $realtobits(4294967296.0);
    vals[21] = $realtobits(9223372036854775808.0);
    vals[22] = $realtobits(-9223372036854775808.0);
    vals[23] = $realtobits(9223372036854774784.0);
    vals[24] = $realtobits(18446744073709551616.0);
    vals[25] = $realtobits(18446744073709549568.0);
    vals[26] = $realtobits(-18446744073709551616.0);
    vals[27] = 64'h4630_0000_0000_0123;
    vals[28] = 64'h47EF_FFFF_FFFF_FFFF;
    vals[29] = 64'h47F0_0000_0000_0000;
    vals[30] = 64'hC800_0000_0000_0000;
    vals[31] = $realtobits(1.0e300);
    vals[32] = 64'h7FF0_0000_0000_0000;
    vals[33] = 64'hFFF0_0000_0000_0000;
    vals[34] = 64'h7FF8_0000_0000_0000;
    vals[35] = 64'h7FF0_0000_0000_0001;
    vals[36] = 64'hFFF4_0000_0000_0000;
    vals[37] = $realtobits(123456789.123);
    vals[38] = $realtobits(-1.0e10);
    vals[39] = $realtobits(-4503599627370497.0);
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    chk("R12", "reset_outputs", {result[62:0], done}, 64'd0);
    chk("R12", "reset_flags", {55'd0, wr_en, flag_rounded, flag_inexact, req_snan_inv,
        req_cvt_inv, req_inexact, ovf, bad_mode, done}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R12", "idle_done", {63'd0, done}, 64'd0);

    // R1: rounding selection on 2.5 and -2.5, signed 32-bit
    drive($realtobits(2.5), 3'd0, 2'b00, 1'b0, 2'b10, 1'b0);
    chk("R1", "ceil_2.5", result, 64'd3);
    drive($realtobits(2.5), 3'd4, 2'b00, 1'b0, 2'b10, 1'b0);
    chk("R1", "forced_trunc_2.5", result, 64'd2);
    drive($realtobits(2.5), 3'd0, 2'b00, 1'b0, 2'b00, 1'b0);
    chk("R1", "even_2.5", result, 64'd2);
    drive($realtobits(-2.5), 3'd2, 2'b00, 1'b0, 2'b11, 1'b0);
    chk("R1", "floor_-2.5", result, 64'hFFFF_FFFF_FFFF_FFFD);
    // R2: extension of 32-bit results
    drive($realtobits(-1.0), 3'd0, 2'b00, 1'b0, 2'b00, 1'b0);
    chk("R2", "s32_sign_ext", result, 64'hFFFF_FFFF_FFFF_FFFF);
    drive($realtobits(4294967295.0), 3'd0, 2'b01, 1'b0, 2'b00, 1'b0);
    chk("R2", "u32_zero_ext", result, 64'h0000_0000_FFFF_FFFF);
    // R7: low fraction bits dropped in single mode
    drive(64'h3FF0_0000_0000_0001, 3'd0, 2'b00, 1'b1, 2'b10, 1'b0);
    chk("R7", "single_narrow", {result[61:0], flag_inexact, ovf}, {62'd1, 1'b0, 1'b0});
    drive(64'h3FF0_0000_0000_0001, 3'd0, 2'b00, 1'b0, 2'b10, 1'b0);
    chk("R7", "double_keeps_bits", {result[61:0], flag_inexact, ovf}, {62'd2, 1'b1, 1'b1});

    for (int vi = 0; vi < 40; vi++)
      for (int mi = 0; mi < 8; mi++)
        for (int ki = 0; ki < 4; ki++)
          for (int si = 0; si < 2; si++)
            for (int ri = 0; ri < 4; ri++)
              for (int ti = 0; ti < 2; ti++)
                run_one(vals[vi], 3'(mi), 2'(ki), 1'(si), 2'(ri), 1'(ti));

    @(posedge clk);
    #1;
    chk("R12", "idle_after_run", {62'd0, done, wr_en}, 64'd0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule